// File: doc/BRIEF.md
# Compiler-Scheduled Static Mesh Switch

This block is the per-tile switch of a two-dimensional mesh of processing tiles. It carries 32-bit words between the tile's four mesh neighbours and its local processor. Packet headers play no part in its routing. A small local instruction store holds a routing program that a compiler has written ahead of time. Each program word says, for every output channel, which input channel feeds it.

The switch runs that program one word at a time. A word takes effect atomically, and only once every input it reads holds data and every output it writes has room. Until then the program counter stays where it is. Because of this, the words on every channel appear in the order the compiler planned, however the neighbours stall. Every input channel is buffered in a register FIFO where it enters the switch, so no wire longer than one tile is needed. Every output channel also leaves through a FIFO. The program store is filled through a plain write port, normally while reset is held.

Top module: `ssw_static_switch`

## Requirements
- R1: While reset is held and just after it, every `out_valid` bit is 0 and every `in_ready` bit is 1. The program counter starts at address 0.
- R2: Channel index order is north=0, east=1, south=2, west=3, processor=4. A program word holds a 3-bit source code per output, with output k in bits [3k+2:3k]. Codes 1..5 pick input 0..4. Codes 0, 6 and 7 leave that output unused.
- R3: A program word commits only when every input it selects is non-empty and every output it uses is not full. While it waits, no input is dequeued, no output is written, and the program counter holds.
- R4: One input may feed several outputs in the same commit. Each input that is read is dequeued exactly once per commit, however many outputs it feeds.
- R5: Every output channel delivers words in the order the program moved them. A word offered with `out_ready` low stays valid and unchanged until it is taken.
- R6: Bit 15 of a program word is a jump flag. On commit, the next address is bits [19:16] when the flag is set. Otherwise it is the current address plus one, wrapping to 0 after the last entry.
- R7: When the program word is already waiting for it, a word accepted on an input at one clock edge is offered on its output after the following edge. That is two edges in total.
- R8: Each input buffers up to FIFO_DEPTH words. `in_ready` goes low once that many words are held and none can leave.
- R9: Asserting `imem_we` stores `imem_wdata` at `imem_addr`. The switch executes that word when its program counter reaches the address.
- R10: A program word that uses no output commits at once and only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input word offered |
| in_ready | output | 5 | Per-input buffer has room |
| in_data | input | 5x32 | Per-input word |
| out_valid | output | 5 | Per-output word available |
| out_ready | input | 5 | Per-output consumer takes word |
| out_data | output | 5x32 | Per-output word |
| imem_we | input | 1 | Program store write strobe |
| imem_addr | input | 4 | Program store write address |
| imem_wdata | input | 20 | Program word to store |

## Verification
The hardest case to reach is a program word that fans several inputs out to several outputs while some of its operands are present and others are missing. At the same moment, one of the outputs it would write may be full. Random programs of eight words are run against random valid and ready patterns on all ten channels. The inputs get exactly the words that an abstract run of sixty program steps consumes. The bench compares every output stream with that abstract run. Any commit that is partial, early or duplicated shows up as a wrong or extra word. Directed cases pin down the two-edge latency, back-pressure that fills both FIFO levels, and a five-way fan-out from one input.

// File: rtl/ssw_pkg.sv
`timescale 1ns/1ps
package ssw_pkg;

    localparam int unsigned NPORT   = 5;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned ROUTE_W = NPORT * SEL_W;

    // Source codes; channel index = code - 1
    typedef enum logic [SEL_W-1:0] {
        SRC_NONE  = 3'd0,
        SRC_NORTH = 3'd1,
        SRC_EAST  = 3'd2,
        SRC_SOUTH = 3'd3,
        SRC_WEST  = 3'd4,
        SRC_PROC  = 3'd5
    } src_e;

    function automatic logic src_is_live(input logic [SEL_W-1:0] code);
        return (code >= SRC_NORTH) && (code <= SRC_PROC);
    endfunction

    function automatic logic [SEL_W-1:0] src_channel(input logic [SEL_W-1:0] code);
        return code - 3'd1;
    endfunction

endpackage

// File: rtl/ssw_fifo.sv
`timescale 1ns/1ps
module ssw_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          not_empty,
    output logic          not_full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] slot_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign not_empty = (st_q.cnt != '0);
    assign not_full  = (st_q.cnt != CW'(DEPTH));
    assign head      = slot_q[st_q.rd];
    assign do_push   = push && not_full;
    assign do_pop    = pop && not_empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[st_q.wr] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> not_full); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty); // R3

endmodule

// File: rtl/ssw_xbar.sv
`timescale 1ns/1ps
module ssw_xbar
    import ssw_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [NPORT-1:0][SEL_W-1:0] route,
    input  logic                        commit,
    input  logic [NPORT-1:0][DW-1:0]    in_head,
    output logic [NPORT-1:0]            need_in,
    output logic [NPORT-1:0]            use_out,
    output logic [NPORT-1:0]            in_pop,
    output logic [NPORT-1:0]            out_push,
    output logic [NPORT-1:0][DW-1:0]    out_data
);
    logic [NPORT-1:0][NPORT-1:0] pick; // pick[o][i]: output o reads input i

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        always_comb begin
            pick[o]     = '0;
            use_out[o]  = src_is_live(route[o]);
            out_data[o] = '0;
            if (use_out[o]) begin
                pick[o][src_channel(route[o])] = 1'b1;
                out_data[o] = in_head[src_channel(route[o])];
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        always_comb begin
            need_in[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                need_in[i] = need_in[i] | pick[o][i];
            end
        end
    end

    // a shared input is popped once regardless of fan-out
    assign in_pop   = commit ? need_in : '0;
    assign out_push = commit ? use_out : '0;

endmodule

// File: rtl/ssw_seq.sv
`timescale 1ns/1ps
module ssw_seq
    import ssw_pkg::*;
#(
    parameter int unsigned IMEM_DEPTH = 16,
    parameter int unsigned PC_W       = 4,
    parameter int unsigned INSTR_W    = ROUTE_W + 1 + PC_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PC_W-1:0]             wr_addr,
    input  logic [INSTR_W-1:0]          wr_data,
    input  logic [NPORT-1:0]            need_in,
    input  logic [NPORT-1:0]            in_avail,
    input  logic [NPORT-1:0]            use_out,
    input  logic [NPORT-1:0]            out_space,
    output logic [NPORT-1:0][SEL_W-1:0] route,
    output logic                        commit
);
    localparam int unsigned JMP_BIT = ROUTE_W;
    localparam int unsigned TGT_LO  = ROUTE_W + 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_st_t;

    seq_st_t            st_d, st_q;
    logic [INSTR_W-1:0] prog_q [IMEM_DEPTH];
    logic [INSTR_W-1:0] instr;
    logic               jump;
    logic [PC_W-1:0]    target;
    logic               operands_ok, space_ok;

    assign instr  = prog_q[st_q.pc];
    assign route  = instr[ROUTE_W-1:0];
    assign jump   = instr[JMP_BIT];
    assign target = instr[INSTR_W-1:TGT_LO];

    assign operands_ok = &(~need_in | in_avail);
    assign space_ok    = &(~use_out | out_space);
    assign commit      = operands_ok && space_ok;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            if (jump)                               st_d.pc = target;
            else if (st_q.pc == PC_W'(IMEM_DEPTH-1)) st_d.pc = '0;
            else                                    st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) prog_q[wr_addr] <= wr_data;
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.pc)); // R3
    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && jump) |=> (st_q.pc == $past(target))); // R6

endmodule

// File: rtl/ssw_static_switch.sv
`timescale 1ns/1ps
module ssw_static_switch
    import ssw_pkg::*;
#(
    parameter  int unsigned DATA_W     = 32,
    parameter  int unsigned FIFO_DEPTH = 4,
    parameter  int unsigned IMEM_DEPTH = 16,
    localparam int unsigned PC_W       = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1,
    localparam int unsigned INSTR_W    = ROUTE_W + 1 + PC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             in_valid,
    output logic [NPORT-1:0]             in_ready,
    input  logic [NPORT-1:0][DATA_W-1:0] in_data,
    output logic [NPORT-1:0]             out_valid,
    input  logic [NPORT-1:0]             out_ready,
    output logic [NPORT-1:0][DATA_W-1:0] out_data,
    input  logic                         imem_we,
    input  logic [PC_W-1:0]              imem_addr,
    input  logic [INSTR_W-1:0]           imem_wdata
);
    logic [NPORT-1:0][DATA_W-1:0] in_head;
    logic [NPORT-1:0]             in_avail;
    logic [NPORT-1:0]             in_pop;
    logic [NPORT-1:0]             need_in, use_out;
    logic [NPORT-1:0]             out_space, out_push;
    logic [NPORT-1:0][DATA_W-1:0] xbar_data;
    logic [NPORT-1:0][SEL_W-1:0]  route;
    logic                         commit;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        ssw_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_valid[g] && in_ready[g]),
            .push_data (in_data[g]),
            .pop       (in_pop[g]),
            .head      (in_head[g]),
            .not_empty (in_avail[g]),
            .not_full  (in_ready[g])
        );

        ssw_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (out_push[g]),
            .push_data (xbar_data[g]),
            .pop       (out_valid[g] && out_ready[g]),
            .head      (out_data[g]),
            .not_empty (out_valid[g]),
            .not_full  (out_space[g])
        );

        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && !out_ready[g]) |=> (out_valid[g] && $stable(out_data[g]))); // R5
    end

    ssw_seq #(.IMEM_DEPTH(IMEM_DEPTH), .PC_W(PC_W), .INSTR_W(INSTR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (imem_we),
        .wr_addr   (imem_addr),
        .wr_data   (imem_wdata),
        .need_in   (need_in),
        .in_avail  (in_avail),
        .use_out   (use_out),
        .out_space (out_space),
        .route     (route),
        .commit    (commit)
    );

    ssw_xbar #(.DW(DATA_W)) u_xbar (
        .route    (route),
        .commit   (commit),
        .in_head  (in_head),
        .need_in  (need_in),
        .use_out  (use_out),
        .in_pop   (in_pop),
        .out_push (out_push),
        .out_data (xbar_data)
    );

    AST_MOVE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_pop) |-> (|out_push)); // R4

endmodule

// File: tb/tb_ssw_static_switch.sv
`timescale 1ns/1ps
module tb_ssw_static_switch;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [4:0]        in_valid;
    logic [4:0]        in_ready;
    logic [4:0][31:0]  in_data;
    logic [4:0]        out_valid;
    logic [4:0]        out_ready;
    logic [4:0][31:0]  out_data;
    logic              imem_we;
    logic [3:0]        imem_addr;
    logic [19:0]       imem_wdata;

    always #2 clk = ~clk;

    ssw_static_switch dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [19:0] prog [16];
    logic [31:0] stim [5][256];
    logic [31:0] expq [5][256];
    int          need [5];
    int          ecnt [5];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2 layout: output k field at [3k+2:3k], jump bit 15, target [19:16]
    function automatic logic [19:0] mk(input int sn, input int se, input int ss,
                                       input int sw, input int sp, input bit j, input int t);
        return {t[3:0], j, sp[2:0], sw[2:0], ss[2:0], se[2:0], sn[2:0]};
    endfunction

    task automatic reset_load(input int n);
        rst_n = 1'b0; in_valid = '0; out_ready = '0; in_data = '0; imem_we = 1'b0;
        @(negedge clk);
        for (int a = 0; a < n; a++) begin
            imem_we = 1'b1; imem_addr = a[3:0]; imem_wdata = prog[a];
            @(negedge clk);
        end
        imem_we = 1'b0;
        @(negedge clk);
        chk(out_valid == 5'h00, "R1 out_valid in reset", {27'd0, out_valid}, 32'h0);
        chk(in_ready == 5'h1f, "R1 in_ready in reset", {27'd0, in_ready}, 32'h1f);
        rst_n = 1'b1;
    endtask

    task automatic send(input int p, input logic [31:0] d);
        @(negedge clk);
        in_valid[p] = 1'b1; in_data[p] = d;
        for (int k = 0; k < 40 && !in_ready[p]; k++) @(negedge clk);
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic take(input int o, input logic [31:0] e, input string req);
        for (int k = 0; k < 40 && !out_valid[o]; k++) @(negedge clk);
        chk(out_valid[o] && out_data[o] == e, req, out_data[o], e);
        out_ready[o] = 1'b1;
        @(negedge clk);
        out_ready[o] = 1'b0;
    endtask

    task automatic rand_round(input int steps);
        int pc;
        int sent [5];
        int got  [5];
        bit fire [5];
        bit all_done;
        for (int a = 0; a < 8; a++) begin
            int c [5];
            for (int o = 0; o < 5; o++) begin
                int r = $urandom_range(0, 9);
                c[o] = (r == 0) ? 6 + $urandom_range(0, 1) : (r < 5 ? 0 : r - 4);
            end
            prog[a] = mk(c[0], c[1], c[2], c[3], c[4],
                         (a == 7) ? 1'b1 : ($urandom_range(0, 3) == 0),
                         $urandom_range(0, 7));
        end
        for (int i = 0; i < 5; i++) begin
            need[i] = 0; ecnt[i] = 0; sent[i] = 0; got[i] = 0; fire[i] = 1'b0;
            for (int k = 0; k < 256; k++) stim[i][k] = $urandom;
        end
        pc = 0;
        for (int s = 0; s < steps; s++) begin
            logic [19:0] w = prog[pc];
            logic [4:0]  used = '0;
            for (int o = 0; o < 5; o++) begin
                int code = int'(w[o*3 +: 3]);
                if (code >= 1 && code <= 5) begin
                    expq[o][ecnt[o]] = stim[code-1][need[code-1]];
                    ecnt[o]++;
                    used[code-1] = 1'b1;
                end
            end
            for (int i = 0; i < 5; i++) if (used[i]) need[i]++;
            pc = w[15] ? int'(w[19:16]) : pc + 1;
        end
        reset_load(8);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            all_done = 1'b1;
            for (int i = 0; i < 5; i++) begin
                if (fire[i]) sent[i]++;
                in_valid[i] = (sent[i] < need[i]) && ($urandom_range(0, 3) != 0);
                in_data[i]  = stim[i][sent[i] & 255];
                fire[i]     = in_valid[i] && in_ready[i];
                if (sent[i] < need[i] || fire[i]) all_done = 1'b0;
            end
            for (int o = 0; o < 5; o++) begin
                out_ready[o] = ($urandom_range(0, 2) != 0);
                if (out_valid[o] && out_ready[o]) begin
                    chk(got[o] < ecnt[o] && out_data[o] == expq[o][got[o] & 255],
                        "R3/R4/R5/R6 stream word", out_data[o], expq[o][got[o] & 255]);
                    got[o]++;
                end
                if (got[o] < ecnt[o]) all_done = 1'b0;
            end
            if (all_done) break;
        end
        in_valid = '0;
        out_ready = 5'h1f;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            for (int o = 0; o < 5; o++) begin
                if (out_valid[o]) begin
                    chk(1'b0, "R3/R4 extra word", out_data[o], 32'h0);
                    got[o]++;
                end
            end
        end
        out_ready = '0;
        for (int o = 0; o < 5; o++)
            chk(got[o] == ecnt[o], "R5 stream length", got[o], ecnt[o]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        // R7 / R9 / R1: east <- north, jump to self
        for (int a = 0; a < 16; a++) prog[a] = 20'h0;
        prog[0] = mk(0, 1, 0, 0, 0, 1'b1, 0);
        reset_load(1);
        in_valid[0] = 1'b1; in_data[0] = 32'hA5A5_0001;
        @(negedge clk);
        in_valid[0] = 1'b0;
        chk(out_valid == 5'h00, "R7 not yet after first edge", {27'd0, out_valid}, 32'h0);
        @(negedge clk);
        chk(out_valid == 5'b00010, "R7 valid after second edge", {27'd0, out_valid}, 32'h2);
        chk(out_data[1] == 32'hA5A5_0001, "R9 stored word executed", out_data[1], 32'hA5A5_0001);
        take(1, 32'hA5A5_0001, "R2 east data");
        chk(out_valid == 5'h00, "R5 drained", {27'd0, out_valid}, 32'h0);

        // R3 operands: south <- north, proc <- west
        prog[0] = mk(0, 0, 1, 0, 4, 1'b1, 0);
        reset_load(1);
        send(0, 32'h1111_0000);
        repeat (5) @(negedge clk);
        chk(out_valid == 5'h00, "R3 waits for missing west operand", {27'd0, out_valid}, 32'h0);
        send(3, 32'h2222_0000);
        repeat (2) @(negedge clk);
        chk(out_valid == 5'b10100, "R3 both outputs after operands", {27'd0, out_valid}, 32'h14);
        take(2, 32'h1111_0000, "R3 south word");
        take(4, 32'h2222_0000, "R3 proc word");

        // R3 space / R8 / R5: east <- north with east blocked
        prog[0] = mk(0, 1, 0, 0, 0, 1'b1, 0);
        reset_load(1);
        for (int k = 0; k < 8; k++) send(0, 32'h3000_0000 + k);
        repeat (3) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R8 input full at depth", {31'd0, in_ready[0]}, 32'h0);
        chk(out_valid == 5'b00010, "R3 only east holds data", {27'd0, out_valid}, 32'h2);
        for (int k = 0; k < 8; k++) take(1, 32'h3000_0000 + k, "R5 order under back-pressure");
        chk(in_ready[0] == 1'b1, "R8 input drained", {31'd0, in_ready[0]}, 32'h1);

        // R4: processor input fans out to all five outputs
        prog[0] = mk(5, 5, 5, 5, 5, 1'b1, 0);
        reset_load(1);
        send(4, 32'hFACE_0004);
        repeat (2) @(negedge clk);
        chk(out_valid == 5'h1f, "R4 all outputs valid", {27'd0, out_valid}, 32'h1f);
        for (int o = 0; o < 5; o++)
            chk(out_data[o] == 32'hFACE_0004, "R4 fan-out word", out_data[o], 32'hFACE_0004);
        out_ready = 5'h1f;
        @(negedge clk);
        out_ready = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 5'h00, "R4 input dequeued once", {27'd0, out_valid}, 32'h0);

        // R6 / R10: idle word, then east, south with jump back to 1
        prog[0] = mk(0, 0, 0, 0, 0, 1'b0, 0);
        prog[1] = mk(0, 1, 0, 0, 0, 1'b0, 0);
        prog[2] = mk(0, 0, 1, 0, 0, 1'b1, 1);
        reset_load(3);
        for (int k = 0; k < 4; k++) send(0, 32'h6000_0000 + k);
        repeat (3) @(negedge clk);
        chk(out_valid == 5'b00110, "R10 idle word advanced", {27'd0, out_valid}, 32'h6);
        take(1, 32'h6000_0000, "R6 east first");
        take(1, 32'h6000_0002, "R6 east after jump");
        take(2, 32'h6000_0001, "R6 south first");
        take(2, 32'h6000_0003, "R6 south after jump");

        // constrained random programs
        for (int r = 0; r < 4; r++) rand_round(60);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule